// File: doc/BRIEF.md
# EDH Error Flag Access Port

This block gives external logic synchronous access to the error flags carried in error detection and handling (EDH) packets. There are fifteen error flags in three groups of five (full field, active picture, ancillary) plus two validity bits. A five-bit pin group carries one group at a time, and a two-bit select input picks which group that is. A direction input sets whether the pins are driven by the block (read) or sampled by it (write). The bidirectional pad is split into `flag_in`, `flag_out` and an output enable.

A write replaces the chosen group in the next outgoing packet only. After the packet-sent strobe, the outgoing flags fall back to host overrides or to the normally generated flags. A port override always beats a host override. Writing select code 3 also updates a latched source bit. That bit chooses whether later reads show the flags of the incoming packet or the outgoing flags after all overrides.

Top module: `edh_flag_port`

## Requirements
- R1: `flag_oe` equals `rd_nwr`. When `rd_nwr` is 1 the port is in read mode and the block drives the pins. When `rd_nwr` is 0 the port is in write mode and `flag_in` is sampled.
- R2: For select 0, 1 and 2 a read returns the full-field, active-picture and ancillary group respectively. The bit order is UES on bit 4, IDA on bit 3, IDH on bit 2, EDA on bit 1 and EDH on bit 0.
- R3: For select 3 a read returns {source bit, active-picture validity, full-field validity, 0, 0} on bits 4 down to 0.
- R4: A write is captured on the rising clock edge into the selected group. From the next cycle that group's outgoing value is the written value. For select 3, bit 3 sets the active-picture validity and bit 2 sets the full-field validity.
- R5: A `pkt_sent` pulse clears every pending port override. When a write and `pkt_sent` fall in the same cycle, the written group stays pending for the following packet.
- R6: Each group's outgoing value comes from the first available source in this order: a pending port override, then the host override (`host_en` bit = group index, 3 = validity), then the generated flags.
- R7: When the source bit is 1, reads return the incoming packet's flags and validity bits. When it is 0, reads return the outgoing values after overrides.
- R8: The source bit changes only on a write with select 3, where it takes `flag_in[4]`. Its value has no effect on what error-flag writes store.
- R9: `flag_out` is registered. It reflects the select input and the state from before the previous rising edge, which gives one cycle of latency.
- R10: After reset no override is pending, the source bit is 0 and `flag_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_nwr | input | 1 | 1 = read mode, 0 = write mode |
| grp_sel | input | 2 | Group select |
| flag_in | input | 5 | Pin values sampled in write mode |
| flag_out | output | 5 | Registered pin values for read mode |
| flag_oe | output | 1 | Pad output enable |
| inc_ff | input | 5 | Incoming full-field flags |
| inc_ap | input | 5 | Incoming active-picture flags |
| inc_anc | input | 5 | Incoming ancillary flags |
| inc_apv | input | 1 | Incoming active-picture validity |
| inc_ffv | input | 1 | Incoming full-field validity |
| gen_ff | input | 5 | Generated full-field flags |
| gen_ap | input | 5 | Generated active-picture flags |
| gen_anc | input | 5 | Generated ancillary flags |
| gen_apv | input | 1 | Generated active-picture validity |
| gen_ffv | input | 1 | Generated full-field validity |
| host_en | input | 4 | Host override enable per group |
| host_ff | input | 5 | Host full-field override value |
| host_ap | input | 5 | Host active-picture override value |
| host_anc | input | 5 | Host ancillary override value |
| host_apv | input | 1 | Host active-picture validity override |
| host_ffv | input | 1 | Host full-field validity override |
| pkt_sent | input | 1 | Outgoing packet has left; clears port overrides |
| out_ff | output | 5 | Outgoing full-field flags |
| out_ap | output | 5 | Outgoing active-picture flags |
| out_anc | output | 5 | Outgoing ancillary flags |
| out_apv | output | 1 | Outgoing active-picture validity |
| out_ffv | output | 1 | Outgoing full-field validity |

## Verification
The bench covers four hazards:
- A write and `pkt_sent` in the same cycle. A design that cleared last would lose the write meant for the following packet.
- Host and port overrides active on the same group. A reversed priority would show the host value on the outgoing flags.
- A change of select in the same cycle as the read. A design with the wrong latency would show the new group a cycle early.
- Select-3 writes toggling the source bit between error-flag writes. A design that let the bit steer writes, or that did not latch it, would read back the wrong flag set.

// File: rtl/edh_flag_port.sv
module edh_flag_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_nwr,
  input  logic [1:0] grp_sel,
  input  logic [4:0] flag_in,
  output logic [4:0] flag_out,
  output logic       flag_oe,
  input  logic [4:0] inc_ff,
  input  logic [4:0] inc_ap,
  input  logic [4:0] inc_anc,
  input  logic       inc_apv,
  input  logic       inc_ffv,
  input  logic [4:0] gen_ff,
  input  logic [4:0] gen_ap,
  input  logic [4:0] gen_anc,
  input  logic       gen_apv,
  input  logic       gen_ffv,
  input  logic [3:0] host_en,
  input  logic [4:0] host_ff,
  input  logic [4:0] host_ap,
  input  logic [4:0] host_anc,
  input  logic       host_apv,
  input  logic       host_ffv,
  input  logic       pkt_sent,
  output logic [4:0] out_ff,
  output logic [4:0] out_ap,
  output logic [4:0] out_anc,
  output logic       out_apv,
  output logic       out_ffv
);
  logic [3:0] pend;
  logic [4:0] p_ff, p_ap, p_anc;
  logic [1:0] p_vld;
  logic       src_in;
  logic [4:0] rd_val;
  logic       wr;

  assign wr      = ~rd_nwr;
  assign flag_oe = rd_nwr;

  assign out_ff  = pend[0] ? p_ff  : host_en[0] ? host_ff  : gen_ff;
  assign out_ap  = pend[1] ? p_ap  : host_en[1] ? host_ap  : gen_ap;
  assign out_anc = pend[2] ? p_anc : host_en[2] ? host_anc : gen_anc;
  assign {out_apv, out_ffv} = pend[3] ? p_vld :
                              host_en[3] ? {host_apv, host_ffv} : {gen_apv, gen_ffv};

  always_comb begin
    case (grp_sel)
      2'd0:    rd_val = src_in ? inc_ff  : out_ff;
      2'd1:    rd_val = src_in ? inc_ap  : out_ap;
      2'd2:    rd_val = src_in ? inc_anc : out_anc;
      default: rd_val = {src_in, src_in ? {inc_apv, inc_ffv} : {out_apv, out_ffv}, 2'b00};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= '0;
      p_ff     <= '0;
      p_ap     <= '0;
      p_anc    <= '0;
      p_vld    <= '0;
      src_in   <= 1'b0;
      flag_out <= '0;
    end else begin
      flag_out <= rd_val;
      if (pkt_sent) pend <= '0;
      if (wr) begin
        pend[grp_sel] <= 1'b1;
        case (grp_sel)
          2'd0:    p_ff  <= flag_in;
          2'd1:    p_ap  <= flag_in;
          2'd2:    p_anc <= flag_in;
          default: begin
            src_in <= flag_in[4];
            p_vld  <= flag_in[3:2];
          end
        endcase
      end
    end
  end

  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && grp_sel == 2'd0) |=> (out_ff == $past(flag_in)));
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_sent && rd_nwr) |=> (pend == 4'd0));
  assert_write_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_sent && wr) |=> $onehot0(pend) && pend[$past(grp_sel)]);
  assert_src_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && grp_sel == 2'd3) |=> $stable(src_in));
  assert_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_sel == 2'd3) |=> (flag_out[1:0] == 2'b00));
  assert_port_beats_host_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && grp_sel == 2'd1 && !pkt_sent) ##1 host_en[1] |-> (out_ap == $past(flag_in)));
endmodule

// File: tb/edh_flag_port_test.sv
module edh_flag_port_test;
  logic clk = 0, rst_n = 0;
  logic rd_nwr = 1, pkt_sent = 0;
  logic [1:0] grp_sel = 0;
  logic [4:0] flag_in = 0;
  logic [4:0] inc_ff = 0, inc_ap = 0, inc_anc = 0, gen_ff = 0, gen_ap = 0, gen_anc = 0;
  logic [4:0] host_ff = 0, host_ap = 0, host_anc = 0;
  logic inc_apv = 0, inc_ffv = 0, gen_apv = 0, gen_ffv = 0, host_apv = 0, host_ffv = 0;
  logic [3:0] host_en = 0;
  logic [4:0] flag_out, out_ff, out_ap, out_anc;
  logic flag_oe, out_apv, out_ffv;

  int checks = 0, errors = 0, cycles = 0;
  bit m_pend[4];
  logic [4:0] m_port[4];
  bit m_src;
  logic [4:0] m_fout;

  always #4 clk = ~clk;

  edh_flag_port uut (.*);

  function automatic logic [4:0] grp_out(int g);
    logic [4:0] h, n;
    case (g)
      0: begin h = host_ff;  n = gen_ff;  end
      1: begin h = host_ap;  n = gen_ap;  end
      2: begin h = host_anc; n = gen_anc; end
      default: begin h = {3'b0, host_apv, host_ffv}; n = {3'b0, gen_apv, gen_ffv}; end
    endcase
    if (m_pend[g]) return m_port[g];
    if (host_en[g]) return h;
    return n;
  endfunction

  function automatic logic [4:0] read_val(int g);
    logic [4:0] v;
    case (g)
      0: v = m_src ? inc_ff  : grp_out(0);
      1: v = m_src ? inc_ap  : grp_out(1);
      2: v = m_src ? inc_anc : grp_out(2);
      default: begin
        logic [1:0] b;
        b = m_src ? {inc_apv, inc_ffv} : grp_out(3)[1:0];
        v = {m_src, b, 2'b00};
      end
    endcase
    return v;
  endfunction

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic compare();
    check("R1 flag_oe", {4'b0, flag_oe}, {4'b0, rd_nwr});
    check("R6 out_ff", out_ff, grp_out(0));
    check("R6 out_ap", out_ap, grp_out(1));
    check("R6 out_anc", out_anc, grp_out(2));
    check("R4 validity", {3'b0, out_apv, out_ffv}, grp_out(3));
    check("R2 R3 R7 R9 flag_out", flag_out, m_fout);
  endtask

  // one clock: model update at the edge using inputs held since the last negedge
  task automatic step();
    @(posedge clk);
    m_fout = read_val(grp_sel);
    if (pkt_sent) for (int i = 0; i < 4; i++) m_pend[i] = 0;
    if (!rd_nwr) begin
      m_pend[grp_sel] = 1;
      if (grp_sel == 3) begin
        m_src = flag_in[4];
        m_port[3] = {3'b0, flag_in[3:2]};
      end else m_port[grp_sel] = flag_in;
    end
    cycles++;
    @(negedge clk);
    compare();
  endtask

  task automatic wr(int g, logic [4:0] v);
    rd_nwr = 0; grp_sel = 2'(g); flag_in = v; step(); rd_nwr = 1;
  endtask

  task automatic rd(int g);
    rd_nwr = 1; grp_sel = 2'(g); step();
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_pend[i] = 0; m_port[i] = 0; end
    m_src = 0; m_fout = 0;
    inc_ff = 5'h11; inc_ap = 5'h12; inc_anc = 5'h13; inc_apv = 1; inc_ffv = 0;
    gen_ff = 5'h05; gen_ap = 5'h0A; gen_anc = 5'h14; gen_apv = 0; gen_ffv = 1;
    host_ff = 5'h1F; host_ap = 5'h1E; host_anc = 5'h1D; host_apv = 1; host_ffv = 1;
    repeat (2) @(negedge clk);
    check("R10 reset flag_out", flag_out, 5'b0);
    check("R10 reset out_ff", out_ff, gen_ff);
    rst_n = 1;
    // R2 R9: reads of each group, select changes every cycle
    for (int g = 0; g < 4; g++) rd(g);
    rd(0); rd(2); rd(1);
    // R4 R6: write groups, host enabled underneath
    host_en = 4'hF;
    rd(0);
    wr(0, 5'h03); rd(0);
    wr(1, 5'h1C); rd(1);
    wr(2, 5'h15); rd(2);
    wr(3, 5'b01000); rd(3);
    // R5: packet sent clears all
    pkt_sent = 1; rd(0); pkt_sent = 0; rd(1); rd(3);
    // R5: write and packet sent together
    pkt_sent = 1; wr(1, 5'h07); pkt_sent = 0; rd(1);
    pkt_sent = 1; rd(2); pkt_sent = 0; rd(1);
    // R7 R8: switch to incoming, error writes do not change the source bit
    wr(3, 5'b10100); rd(0); rd(3);
    wr(0, 5'h0F); rd(0); rd(3);
    host_en = 4'h0; rd(1); rd(3);
    wr(3, 5'b00000); rd(0); rd(3);
    // mixed stimulus
    for (int i = 0; i < 400; i++) begin
      rd_nwr = $urandom_range(0, 3) != 0;
      grp_sel = 2'($urandom);
      flag_in = 5'($urandom);
      pkt_sent = $urandom_range(0, 5) == 0;
      host_en = 4'($urandom);
      inc_ff = 5'($urandom); gen_ap = 5'($urandom); host_anc = 5'($urandom);
      gen_ffv = 1'($urandom); inc_apv = 1'($urandom);
      step();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule